// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Controller

This block gathers interrupt requests from sixteen internal channels and presents one active-low request line to the processor. Each channel has three per-channel bits: an enable bit that decides whether a source pulse is recorded, a pending bit that holds a recorded request, and an allow bit that decides whether a pending request reaches the processor. When the processor acknowledges, the block supplies an 8-bit vector on the data bus. The upper bits of the vector come from a programmable base. The lower four bits name the highest-numbered channel that is pending and allowed.

Several peripherals can share one acknowledge line through a priority chain. An active-low enable-in from the device above tells the block that nothing of higher priority is requesting. The block passes an active-low enable-out to the device below only while it has no request of its own. Register accesses use an asynchronous strobe bus with chip select, data strobe, read/write, a 5-bit address and a transfer acknowledge that is driven only while active.

Top module: `irq_vector_ctl`

## Requirements
- R1: A source bit that is high at a rising clock edge sets that channel's pending bit after that edge, but only if the channel's enable bit was already set before the edge. When the enable bit is clear, the pulse is ignored.
- R2: `irq_n` is low whenever at least one channel is both pending and allowed, as seen in the register state after each edge, and no acknowledge cycle has been sampled. Otherwise it is high.
- R3: `irq_n` is high during an acknowledge cycle. An acknowledge cycle is one in which `iack_n` and `ds_n` were sampled low and `cs_n` was sampled high at the last edge.
- R4: `ieo_n` is low only while `iei_n` is low and no channel is both pending and allowed. `ieo_n` follows `iei_n` without a clock delay.
- R5: An access is any cycle in which `ds_n` is sampled low together with `cs_n` or `iack_n`. For an access that the block answers, `dtack_oe` goes high and `dtack_n` goes low after the second edge that follows the sampling edge. Both stay that way until the edge that samples `ds_n` high. For reads and vectors, `rdata_oe` is high over exactly the same window.
- R6: Address bits [4:3] select a group: 0 = enable, 1 = pending, 2 = allow, 3 = vector base. Address bits [2:0] select a byte, and bit j of byte b is channel 8b+j. The base group keeps only data bits [7:4] of byte 0 and reads back as those bits followed by zero bits. Bytes that do not exist read as zero and ignore writes.
- R7: Writing the pending group clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R8: An answered acknowledge returns the vector `{base[7:4], n}`, where n is the highest-numbered channel that is pending and allowed. Channel 15 ranks highest.
- R9: The pending bit of the vectored channel is cleared at the same edge that latches the vector.
- R10: An acknowledge cycle sampled while `iei_n` is high, or while no channel is both pending and allowed, gets no `dtack_oe` and no `rdata_oe`, and it leaves the pending bits unchanged.
- R11: A cycle with `cs_n`, `iack_n` and `ds_n` all sampled low raises `bus_err` one edge after the sampling edge. `bus_err` stays high until one edge after `ds_n` is sampled high. The cycle gets no `dtack_oe` and changes no register.
- R12: Reset clears the enable, pending, allow and base registers. It leaves `irq_n` high, `dtack_oe` and `rdata_oe` low, and `bus_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_pulse | input | 16 | One pulse input per channel |
| cs_n | input | 1 | Chip select, active low |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | High for a read, low for a write |
| addr | input | 5 | Register address: group in [4:3], byte in [2:0] |
| wdata | input | 8 | Write data |
| iack_n | input | 1 | Interrupt acknowledge, active low |
| iei_n | input | 1 | Chain enable from the higher-priority device, active low |
| rdata | output | 8 | Read data or vector |
| rdata_oe | output | 1 | Drive enable for `rdata` |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| dtack_oe | output | 1 | Drive enable for `dtack_n` |
| irq_n | output | 1 | Interrupt request, active low |
| ieo_n | output | 1 | Chain enable to the lower-priority device, active low |
| bus_err | output | 1 | Select and acknowledge were asserted together |

## Verification
Pending bits, and therefore `irq_n` and `ieo_n`, change right after the edge that captures a pulse. Acknowledge and read data appear after the second edge that follows the strobe-sampling edge. The strobe is released at the edge that samples it high, and `bus_err` follows one edge after its sampling edge. The bench drives inputs 6 ns after the falling edge. A behavioural model of the register state and the access phases advances on every rising edge, and the bench compares every output against it 2 ns after each falling edge. Directed transactions also count falling edges from the strobe and check that acknowledge is still inactive one edge early and active exactly when it is due.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;
    localparam int GRP_W  = 2;
    localparam int SEL_W  = ADDR_W - GRP_W;

    typedef enum logic [GRP_W-1:0] {
        GRP_ENABLE = 2'd0,
        GRP_PEND   = 2'd1,
        GRP_ALLOW  = 2'd2,
        GRP_BASE   = 2'd3
    } reg_grp_e;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_WAIT,
        BUS_DONE,
        BUS_SKIP
    } bus_state_e;

    typedef struct packed {
        logic              ds;
        logic              cs;
        logic              ack;
        logic              rd;
        logic              iei;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_sample_t;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NCH = 16,
    localparam int IW = $clog2(NCH)
) (
    input  logic [NCH-1:0] req,
    output logic           hit,
    output logic [IW-1:0]  idx
);
    // later (higher-numbered) channels overwrite earlier ones: top channel wins
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < NCH; i++) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_chan_regs.sv
module irq_chan_regs
    import irq_vec_pkg::*;
#(
    parameter int NCH = 16,
    localparam int IW = $clog2(NCH),
    localparam int NBYTE = NCH / DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    src,
    input  logic              wr_en,
    input  reg_grp_e          wr_grp,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_en,
    input  logic [IW-1:0]     clr_idx,
    output logic [NCH-1:0]    en_q,
    output logic [NCH-1:0]    pend_q,
    output logic [NCH-1:0]    allow_q
);
    typedef struct packed {
        logic [NCH-1:0] en;
        logic [NCH-1:0] pend;
        logic [NCH-1:0] allow;
    } chan_t;

    chan_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        for (int b = 0; b < NBYTE; b++) begin
            if (wr_en && int'(wr_sel) == b) begin
                case (wr_grp)
                    GRP_ENABLE: nxt_d.en[b*DATA_W +: DATA_W]    = wr_data;
                    GRP_PEND:   nxt_d.pend[b*DATA_W +: DATA_W]  = cur_q.pend[b*DATA_W +: DATA_W] & wr_data;
                    GRP_ALLOW:  nxt_d.allow[b*DATA_W +: DATA_W] = wr_data;
                    default:    ;
                endcase
            end
        end
        if (clr_en) begin
            nxt_d.pend[clr_idx] = 1'b0;
        end
        // capture uses the enable bits held before this edge
        nxt_d.pend = nxt_d.pend | (src & cur_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign en_q    = cur_q.en;
    assign pend_q  = cur_q.pend;
    assign allow_q = cur_q.allow;

    // R1: a pending bit only appears where the enable bit was already set
    a_r1_capture_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

    // R9: the vectored channel is cleared unless a fresh pulse arrives on it
    a_r9_vector_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !src[clr_idx]) |=> !pend_q[$past(clr_idx)]);
endmodule

// File: rtl/irq_bus_ctl.sv
module irq_bus_ctl
    import irq_vec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ds_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              iack_n,
    input  logic              iei_n,
    input  logic              req_hit,
    input  logic [DATA_W-1:0] vec_in,
    input  logic [DATA_W-1:0] rd_val,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_wdata,
    output logic              wr_fire,
    output logic              ack_fire,
    output logic              ack_seen,
    output logic              dtack_oe,
    output logic              dout_en,
    output logic [DATA_W-1:0] dout,
    output logic              bus_err
);
    typedef struct packed {
        bus_state_e        st;
        bus_sample_t       smp;
        logic [DATA_W-1:0] dout;
        logic              drive;
        logic              err;
    } bus_t;

    bus_t cur_q, nxt_d;

    always_comb begin
        nxt_d           = cur_q;
        nxt_d.smp.ds    = !ds_n;
        nxt_d.smp.cs    = !cs_n;
        nxt_d.smp.ack   = !iack_n;
        nxt_d.smp.rd    = rw;
        nxt_d.smp.iei   = !iei_n;
        nxt_d.smp.addr  = addr;
        nxt_d.smp.wdata = wdata;
        wr_fire         = 1'b0;
        ack_fire        = 1'b0;
        case (cur_q.st)
            BUS_IDLE: begin
                if (cur_q.smp.ds && (cur_q.smp.cs || cur_q.smp.ack)) begin
                    if (cur_q.smp.cs && cur_q.smp.ack) begin
                        nxt_d.st  = BUS_SKIP;
                        nxt_d.err = 1'b1;
                    end else if (cur_q.smp.ack && (!cur_q.smp.iei || !req_hit)) begin
                        nxt_d.st = BUS_SKIP;
                    end else begin
                        nxt_d.st = BUS_WAIT;
                    end
                end
            end
            BUS_WAIT: begin
                if (!cur_q.smp.ds) begin
                    nxt_d.st = BUS_IDLE;
                end else if (cur_q.smp.ack && !req_hit) begin
                    nxt_d.st = BUS_SKIP;
                end else begin
                    nxt_d.st = BUS_DONE;
                    if (cur_q.smp.ack) begin
                        ack_fire    = 1'b1;
                        nxt_d.dout  = vec_in;
                        nxt_d.drive = 1'b1;
                    end else if (cur_q.smp.rd) begin
                        nxt_d.dout  = rd_val;
                        nxt_d.drive = 1'b1;
                    end else begin
                        wr_fire     = 1'b1;
                        nxt_d.drive = 1'b0;
                    end
                end
            end
            BUS_DONE: begin
                if (!cur_q.smp.ds) begin
                    nxt_d.st    = BUS_IDLE;
                    nxt_d.drive = 1'b0;
                end
            end
            default: begin
                if (!cur_q.smp.ds) begin
                    nxt_d.st  = BUS_IDLE;
                    nxt_d.err = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign lat_addr  = cur_q.smp.addr;
    assign lat_wdata = cur_q.smp.wdata;
    assign ack_seen  = cur_q.smp.ds && cur_q.smp.ack && !cur_q.smp.cs;
    assign dtack_oe  = (cur_q.st == BUS_DONE) && cur_q.smp.ds;
    assign dout_en   = dtack_oe && cur_q.drive;
    assign dout      = cur_q.dout;
    assign bus_err   = cur_q.err;

    // R5: acknowledge only after the strobe was low for the two preceding sampling edges
    a_r5_dtack_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dtack_oe) |-> (!$past(ds_n, 2) && !$past(ds_n, 3)));

    // R11: a flagged conflict never acknowledges
    a_r11_no_dtack_on_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> !dtack_oe);

    // R11: the flag only rises after select and acknowledge were seen together
    a_r11_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_err) |-> $past(!cs_n && !iack_n, 2));
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
    import irq_vec_pkg::*;
#(
    parameter int NCH = 16,
    localparam int IW = $clog2(NCH),
    localparam int NBYTE = NCH / DATA_W,
    localparam int BASE_W = DATA_W - IW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    src_pulse,
    input  logic              cs_n,
    input  logic              ds_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              iack_n,
    input  logic              iei_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              dtack_n,
    output logic              dtack_oe,
    output logic              irq_n,
    output logic              ieo_n,
    output logic              bus_err
);
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic              wr_fire, ack_fire, ack_seen;
    logic [NCH-1:0]    en_q, pend_q, allow_q;
    logic              pick_hit;
    logic [IW-1:0]     pick_idx;
    logic [BASE_W-1:0] base_q, base_d;
    logic [DATA_W-1:0] rd_val, vec;
    reg_grp_e          lat_grp;
    logic [SEL_W-1:0]  lat_sel;

    assign lat_grp = reg_grp_e'(lat_addr[ADDR_W-1 -: GRP_W]);
    assign lat_sel = lat_addr[SEL_W-1:0];

    function automatic logic [DATA_W-1:0] pick_byte(input logic [NCH-1:0] v,
                                                    input logic [SEL_W-1:0] sel);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int b = 0; b < NBYTE; b++) begin
            if (int'(sel) == b) r = v[b*DATA_W +: DATA_W];
        end
        return r;
    endfunction

    always_comb begin
        case (lat_grp)
            GRP_ENABLE: rd_val = pick_byte(en_q, lat_sel);
            GRP_PEND:   rd_val = pick_byte(pend_q, lat_sel);
            GRP_ALLOW:  rd_val = pick_byte(allow_q, lat_sel);
            default:    rd_val = (lat_sel == '0) ? {base_q, {IW{1'b0}}} : '0;
        endcase
    end

    always_comb begin
        base_d = base_q;
        if (wr_fire && lat_grp == GRP_BASE && lat_sel == '0) begin
            base_d = lat_wdata[DATA_W-1 -: BASE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_d;
    end

    assign vec = {base_q, pick_idx};

    irq_prio_pick #(.NCH(NCH)) u_pick (
        .req (pend_q & allow_q),
        .hit (pick_hit),
        .idx (pick_idx)
    );

    irq_chan_regs #(.NCH(NCH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (src_pulse),
        .wr_en   (wr_fire),
        .wr_grp  (lat_grp),
        .wr_sel  (lat_sel),
        .wr_data (lat_wdata),
        .clr_en  (ack_fire),
        .clr_idx (pick_idx),
        .en_q    (en_q),
        .pend_q  (pend_q),
        .allow_q (allow_q)
    );

    irq_bus_ctl u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .ds_n      (ds_n),
        .rw        (rw),
        .addr      (addr),
        .wdata     (wdata),
        .iack_n    (iack_n),
        .iei_n     (iei_n),
        .req_hit   (pick_hit),
        .vec_in    (vec),
        .rd_val    (rd_val),
        .lat_addr  (lat_addr),
        .lat_wdata (lat_wdata),
        .wr_fire   (wr_fire),
        .ack_fire  (ack_fire),
        .ack_seen  (ack_seen),
        .dtack_oe  (dtack_oe),
        .dout_en   (rdata_oe),
        .dout      (rdata),
        .bus_err   (bus_err)
    );

    assign dtack_n = !dtack_oe;
    assign irq_n   = !pick_hit || ack_seen;
    assign ieo_n   = iei_n || pick_hit;

    // R8: a vector is only issued for a channel that is pending and allowed
    a_r8_vector_from_request: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |-> (pend_q[pick_idx] && allow_q[pick_idx]));
endmodule

// File: tb/sim_irq_vector_ctl.sv
module sim_irq_vector_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_pulse = '0;
    logic        cs_n = 1'b1, ds_n = 1'b1, rw = 1'b1, iack_n = 1'b1, iei_n = 1'b0;
    logic [4:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rdata_oe, dtack_n, dtack_oe, irq_n, ieo_n, bus_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 20 time units per period: 50 MHz with ns units

    irq_vector_ctl u0 (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .cs_n(cs_n), .ds_n(ds_n),
        .rw(rw), .addr(addr), .wdata(wdata), .iack_n(iack_n), .iei_n(iei_n),
        .rdata(rdata), .rdata_oe(rdata_oe), .dtack_n(dtack_n), .dtack_oe(dtack_oe),
        .irq_n(irq_n), .ieo_n(ieo_n), .bus_err(bus_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_en, m_pend, m_allow;
    logic [3:0]  m_base;
    logic [7:0]  m_dout;
    int          m_ph;            // 0 idle, 1 waiting, 2 answered, 3 ignored
    bit          m_drive, m_err;
    bit          s_ds, s_cs, s_ack, s_rd, s_iei;
    logic [4:0]  s_addr;
    logic [7:0]  s_wd;

    function automatic int top_ch(input logic [15:0] v);
        int r = -1;
        for (int i = 0; i < 16; i++) if (v[i]) r = i;
        return r;
    endfunction

    function automatic logic [7:0] model_read(input logic [4:0] a);
        int g = int'(a[4:3]);
        int b = int'(a[2:0]);
        logic [15:0] v;
        if (g == 3) return (b == 0) ? {m_base, 4'h0} : 8'h00;
        v = (g == 0) ? m_en : (g == 1) ? m_pend : m_allow;
        if (b > 1) return 8'h00;
        return v[b*8 +: 8];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = '0; m_pend = '0; m_allow = '0; m_base = '0; m_dout = '0;
            m_ph = 0; m_drive = 0; m_err = 0;
            s_ds = 0; s_cs = 0; s_ack = 0; s_rd = 0; s_iei = 0; s_addr = '0; s_wd = '0;
        end else begin : step_model
            logic [15:0] np, ne, na;
            logic [3:0]  nb;
            int          nph, hi, g, b;
            np = m_pend; ne = m_en; na = m_allow; nb = m_base; nph = m_ph;
            hi = top_ch(m_pend & m_allow);
            g = int'(s_addr[4:3]);
            b = int'(s_addr[2:0]);
            if (m_ph == 0) begin
                if (s_ds && (s_cs || s_ack)) begin
                    if (s_cs && s_ack) begin nph = 3; m_err = 1; end
                    else if (s_ack && (!s_iei || hi < 0)) nph = 3;
                    else nph = 1;
                end
            end else if (m_ph == 1) begin
                if (!s_ds) nph = 0;
                else if (s_ack && hi < 0) nph = 3;
                else begin
                    nph = 2;
                    if (s_ack) begin
                        m_dout = {m_base, 4'(hi)}; m_drive = 1; np[hi] = 1'b0;
                    end else if (s_rd) begin
                        m_dout = model_read(s_addr); m_drive = 1;
                    end else begin
                        m_drive = 0;
                        if (g == 3) begin
                            if (b == 0) nb = s_wd[7:4];
                        end else if (b < 2) begin
                            for (int j = 0; j < 8; j++) begin
                                if (g == 0) ne[b*8+j] = s_wd[j];
                                else if (g == 1) begin if (!s_wd[j]) np[b*8+j] = 1'b0; end
                                else na[b*8+j] = s_wd[j];
                            end
                        end
                    end
                end
            end else if (m_ph == 2) begin
                if (!s_ds) begin nph = 0; m_drive = 0; end
            end else begin
                if (!s_ds) begin nph = 0; m_err = 0; end
            end
            np = np | (src_pulse & m_en);
            m_pend = np; m_en = ne; m_allow = na; m_base = nb; m_ph = nph;
            s_ds = !ds_n; s_cs = !cs_n; s_ack = !iack_n; s_rd = rw; s_iei = !iei_n;
            s_addr = addr; s_wd = wdata;
        end
    end

    // compare every cycle, 2 units after the falling edge
    always @(negedge clk) begin
        #2;
        if (rst_n) begin : cmp
            bit any, ack_now, exp_dt, exp_oe;
            any     = |(m_pend & m_allow);
            ack_now = s_ds && s_ack && !s_cs;
            exp_dt  = (m_ph == 2) && s_ds;
            exp_oe  = exp_dt && m_drive;
            chk(ack_now ? "R3 model irq_n" : "R2 model irq_n", int'(irq_n), int'(!any || ack_now));
            chk("R4 model ieo_n", int'(ieo_n), int'(iei_n || any));
            chk("R5 model dtack_oe", int'(dtack_oe), int'(exp_dt));
            chk("R5 model dtack_n", int'(dtack_n), int'(!exp_dt));
            chk("R5 model rdata_oe", int'(rdata_oe), int'(exp_oe));
            if (exp_oe) chk(s_ack ? "R8 model vector" : "R6 model rdata", int'(rdata), int'(m_dout));
            chk("R11 model bus_err", int'(bus_err), int'(m_err));
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic step();
        @(negedge clk);
        #6;
    endtask

    task automatic bus_read(input logic [4:0] a, input int exp, input string tag);
        cs_n = 0; ds_n = 0; rw = 1; addr = a;
        step(); step();
        chk("R5 dtack not yet", int'(dtack_oe), 0);
        step();
        chk("R5 dtack due", int'(dtack_oe), 1);
        chk(tag, int'(rdata), exp);
        cs_n = 1; ds_n = 1;
        step();
        chk("R5 dtack released", int'(dtack_oe), 0);
        step();
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        cs_n = 0; ds_n = 0; rw = 0; addr = a; wdata = d;
        step(); step(); step();
        chk("R5 write dtack", int'(dtack_oe), 1);
        chk("R5 write no drive", int'(rdata_oe), 0);
        cs_n = 1; ds_n = 1; rw = 1;
        step(); step();
    endtask

    task automatic ack_cycle(input bit expect_resp, input int exp_vec, input string tag);
        iack_n = 0; ds_n = 0;
        step();
        chk("R3 irq released in ack", int'(irq_n), 1);
        step(); step();
        if (expect_resp) begin
            chk("R8 ack dtack", int'(dtack_oe), 1);
            chk(tag, int'(rdata), exp_vec);
        end else begin
            chk("R10 no dtack", int'(dtack_oe), 0);
            chk("R10 no drive", int'(rdata_oe), 0);
        end
        iack_n = 1; ds_n = 1;
        step(); step();
    endtask

    task automatic pulse(input logic [15:0] m);
        src_pulse = m;
        step();
        src_pulse = '0;
    endtask

    initial begin
        repeat (3) step();
        chk("R12 irq_n in reset", int'(irq_n), 1);
        rst_n = 1;
        step();
        chk("R12 irq_n after reset", int'(irq_n), 1);
        chk("R12 dtack_oe after reset", int'(dtack_oe), 0);
        chk("R12 bus_err after reset", int'(bus_err), 0);
        chk("R4 ieo_n idle", int'(ieo_n), 0);
        bus_read(5'd9, 'h00, "R12 pending clear");

        bus_write(5'd0, 8'hFF);
        bus_write(5'd1, 8'hFF);
        bus_write(5'd16, 8'hFF);
        bus_write(5'd17, 8'hFF);
        bus_write(5'd24, 8'hA7);
        bus_read(5'd1, 'hFF, "R6 enable byte1");
        bus_read(5'd24, 'hA0, "R6 base low bits zero");
        bus_read(5'd2, 'h00, "R6 absent byte");
        bus_read(5'd26, 'h00, "R6 absent base byte");

        pulse(16'h0008);
        chk("R2 irq on pending", int'(irq_n), 0);
        chk("R4 ieo blocked", int'(ieo_n), 1);
        bus_read(5'd8, 'h08, "R1 channel 3 captured");

        bus_write(5'd0, 8'hDF);
        pulse(16'h0020);
        bus_read(5'd8, 'h08, "R1 disabled channel 5 ignored");

        pulse(16'h1000);
        bus_read(5'd9, 'h10, "R1 channel 12 captured");
        ack_cycle(1, 'hAC, "R8 vector channel 12");
        bus_read(5'd9, 'h00, "R9 channel 12 cleared");
        bus_read(5'd8, 'h08, "R9 channel 3 kept");

        iei_n = 1;
        step();
        chk("R4 ieo follows iei", int'(ieo_n), 1);
        ack_cycle(0, 0, "R10 chain blocked");
        iei_n = 0;
        step();
        bus_read(5'd8, 'h08, "R10 pending unchanged");

        ack_cycle(1, 'hA3, "R8 vector channel 3");
        bus_read(5'd8, 'h00, "R9 channel 3 cleared");
        chk("R2 irq idle", int'(irq_n), 1);
        chk("R4 ieo passes", int'(ieo_n), 0);

        pulse(16'h0006);
        bus_write(5'd8, 8'hFD);
        bus_read(5'd8, 'h04, "R7 zero clears one");

        bus_write(5'd16, 8'h00);
        chk("R2 irq masked", int'(irq_n), 1);
        ack_cycle(0, 0, "R10 nothing allowed");
        bus_read(5'd8, 'h04, "R10 masked pending kept");
        bus_write(5'd16, 8'hFF);

        cs_n = 0; iack_n = 0; ds_n = 0; rw = 0; addr = 5'd8; wdata = 8'h00;
        step(); step();
        chk("R11 error flagged", int'(bus_err), 1);
        step();
        chk("R11 no dtack", int'(dtack_oe), 0);
        cs_n = 1; iack_n = 1; ds_n = 1; rw = 1;
        step();
        chk("R11 flag held one edge", int'(bus_err), 1);
        step();
        chk("R11 flag cleared", int'(bus_err), 0);
        bus_read(5'd8, 'h04, "R11 conflicting write ignored");
        ack_cycle(1, 'hA2, "R8 vector channel 2");

        pulse(16'h8001);
        rst_n = 0;
        step();
        rst_n = 1;
        step();
        chk("R12 irq after mid reset", int'(irq_n), 1);
        bus_read(5'd9, 'h00, "R12 pending reset");
        bus_read(5'd0, 'h00, "R12 enable reset");
        bus_read(5'd24, 'h00, "R12 base reset");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule